// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates sixteen interrupt levels for a processor. Each level keeps three state bits: a pending request, an enable and an in-service (active) flag. Hardware sets requests through per-level request lines and a dedicated trap line, which the processor raises when an instruction cannot be executed or when a program asks the executive for service. Software manipulates any of the three bits of any set of levels through mask commands. That lets a program raise an interrupt on its own, and lets it push a level's pending work behind lower-priority levels by marking the level active.

Level 0 is the most urgent. The controller offers the processor the lowest-numbered level that is pending and enabled and that has no equal or more urgent level in service. It also offers the address of that level's two-word vector slot. The processor acknowledges the offer. On that clock edge the level's request clears and its active flag sets. The processor then stores its return address in the first word of the slot and loads the routine entry from the second word. Two levels act as shared lines for up to 64 devices each. For these, the slot address is taken from a separate sub-table and indexed by a 6-bit code from the requesting device. A return command retires the most urgent in-service level, so that less urgent levels can be arbitrated again.

Top module: `pic_top`

## Requirements
- R1: While reset is low, and on the first cycle after it, every request, enable and active bit reads 0 and `irqValid` is 0.
- R2: A high bit of `hwReq` sets the matching request bit at the next clock edge. A high `trapReq` sets the request bit of level `TRAP_LEVEL` (default 4). A hardware set takes effect even when the same cycle clears that bit by command or by acknowledge.
- R3: When `cmdValid` is high, `cmdOp` acts on every level whose `cmdMask` bit is 1, at the next edge. The codes are: 0 sets the request bits, 1 clears them, 2 sets the enable bits, 3 clears them, 4 sets the active bits, 5 clears them, and 7 does nothing.
- R4: `irqValid` is high exactly when some level i has request and enable set and no level j <= i is active. `irqLevel` is the smallest such i. Both follow the state within the same cycle.
- R5: When `irqValid` and `intAck` are both high, the next edge clears the request bit of `irqLevel` and sets its active bit.
- R6: Command code 6 ignores `cmdMask`. It clears only the lowest-numbered active bit and leaves every other active bit unchanged.
- R7: For an offered level that is not a shared line, `vecPairAddr` = `VEC_BASE` + 2 x `irqLevel` (default base 0x0040).
- R8: When the offered level is `PARTY_A` (default 10), `vecPairAddr` = `SUB_BASE_A` + 2 x `subCodeA` (default base 0x0100). When the offered level is `PARTY_B` (default 11), `vecPairAddr` = `SUB_BASE_B` + 2 x `subCodeB` (default base 0x0180).
- R9: A pending request on a disabled level raises no offer and stays pending. Enabling the level later produces the offer.
- R10: `intAck` while `irqValid` is low changes no state bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwReq | input | 16 | Per-level hardware request lines |
| trapReq | input | 1 | Trap request for an unexecutable instruction or a call for executive service |
| subCodeA | input | 6 | Device code on shared line A |
| subCodeB | input | 6 | Device code on shared line B |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code |
| cmdMask | input | 16 | Levels the command acts on |
| intAck | input | 1 | Processor accepts the offered level |
| irqValid | output | 1 | A level is offered |
| irqLevel | output | 4 | Offered level number |
| vecPairAddr | output | 16 | Address of the offered level's two-word vector slot |
| reqState | output | 16 | Request bits |
| enState | output | 16 | Enable bits |
| actState | output | 16 | Active bits |

## Verification
The bench builds the block with its default parameters: sixteen levels, the shared lines at 10 and 11, and the trap at level 4. In that setup every level number from 0 to 15 can be reached, including the extremes, and so can both sub-tables at codes 0 and 63. Random mask commands mixed with acknowledges build deep stacks of nested active levels. Those stacks exercise blocking by an equal or more urgent active level, and returns that uncover the next level. Directed steps pin down a hardware set that overrides a same-cycle clear, a request held on a disabled level, and an acknowledge given while nothing is offered.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_LEVELS = 16;
  localparam int LVL_W = $clog2(NUM_LEVELS);

  typedef enum logic [2:0] {
    OP_SET_REQ = 3'd0,
    OP_CLR_REQ = 3'd1,
    OP_SET_EN  = 3'd2,
    OP_CLR_EN  = 3'd3,
    OP_SET_ACT = 3'd4,
    OP_CLR_ACT = 3'd5,
    OP_RETURN  = 3'd6,
    OP_NONE    = 3'd7
  } picOp_e;

  typedef logic [NUM_LEVELS-1:0] lvlVec_t;

  // control -> datapath strobes, one bit per level
  typedef struct packed {
    lvlVec_t grant;
    lvlVec_t reqSet;
    lvlVec_t reqClr;
    lvlVec_t hwSet;
    lvlVec_t enSet;
    lvlVec_t enClr;
    lvlVec_t actSet;
    lvlVec_t actClr;
  } picStrobe_t;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int TRAP_LEVEL = 4
) (
  input  lvlVec_t          reqQ,
  input  lvlVec_t          enQ,
  input  lvlVec_t          actQ,
  input  lvlVec_t          hwReq,
  input  logic             trapReq,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  lvlVec_t          cmdMask,
  input  logic             intAck,
  output logic             irqValid,
  output logic [LVL_W-1:0] irqLevel,
  output picStrobe_t       strobe
);
  logic             found;
  logic             blocked;
  logic [LVL_W-1:0] pick;
  lvlVec_t          topAct;
  logic             seenAct;
  picOp_e           op;

  assign op = picOp_e'(cmdOp);

  // scan from the most urgent level; an active level stops the scan
  always_comb begin
    found   = 1'b0;
    blocked = 1'b0;
    pick    = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (!found && !blocked) begin
        if (actQ[i]) begin
          blocked = 1'b1;
        end else if (reqQ[i] && enQ[i]) begin
          found = 1'b1;
          pick  = LVL_W'(i);
        end
      end
    end
  end

  // most urgent in-service level, retired by the return command
  always_comb begin
    topAct  = '0;
    seenAct = 1'b0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (!seenAct && actQ[i]) begin
        topAct[i] = 1'b1;
        seenAct   = 1'b1;
      end
    end
  end

  assign irqValid = found;
  assign irqLevel = pick;

  always_comb begin
    strobe = '0;
    if (found && intAck) strobe.grant[pick] = 1'b1;
    if (cmdValid) begin
      case (op)
        OP_SET_REQ: strobe.reqSet = cmdMask;
        OP_CLR_REQ: strobe.reqClr = cmdMask;
        OP_SET_EN:  strobe.enSet  = cmdMask;
        OP_CLR_EN:  strobe.enClr  = cmdMask;
        OP_SET_ACT: strobe.actSet = cmdMask;
        OP_CLR_ACT: strobe.actClr = cmdMask;
        OP_RETURN:  strobe.actClr = topAct;
        default:    ;
      endcase
    end
    strobe.hwSet = hwReq;
    if (trapReq) strobe.hwSet[TRAP_LEVEL] = 1'b1;
  end
endmodule

// File: rtl/pic_dpath.sv
module pic_dpath
  import pic_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          SUB_W      = 6,
  parameter int          PARTY_A    = 10,
  parameter int          PARTY_B    = 11,
  parameter logic [15:0] VEC_BASE   = 16'h0040,
  parameter logic [15:0] SUB_BASE_A = 16'h0100,
  parameter logic [15:0] SUB_BASE_B = 16'h0180
) (
  input  logic              clk,
  input  logic              rstN,
  input  picStrobe_t        strobe,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic [SUB_W-1:0]  subCodeA,
  input  logic [SUB_W-1:0]  subCodeB,
  output lvlVec_t           reqQ,
  output lvlVec_t           enQ,
  output lvlVec_t           actQ,
  output logic [ADDR_W-1:0] vecPairAddr
);
  lvlVec_t reqNext;
  lvlVec_t enNext;
  lvlVec_t actNext;

  // per-level update order: acknowledge, then command, then hardware set
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
    assign reqNext[g] = ((reqQ[g] & ~strobe.grant[g] & ~strobe.reqClr[g])
                         | strobe.reqSet[g]) | strobe.hwSet[g];
    assign enNext[g]  = (enQ[g] & ~strobe.enClr[g]) | strobe.enSet[g];
    assign actNext[g] = ((actQ[g] | strobe.grant[g]) & ~strobe.actClr[g])
                        | strobe.actSet[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= '0;
      enQ  <= '0;
      actQ <= '0;
    end else begin
      reqQ <= reqNext;
      enQ  <= enNext;
      actQ <= actNext;
    end
  end

  always_comb begin
    if (irqLevel == LVL_W'(PARTY_A))
      vecPairAddr = ADDR_W'(SUB_BASE_A) + (ADDR_W'(subCodeA) << 1);
    else if (irqLevel == LVL_W'(PARTY_B))
      vecPairAddr = ADDR_W'(SUB_BASE_B) + (ADDR_W'(subCodeB) << 1);
    else
      vecPairAddr = ADDR_W'(VEC_BASE) + (ADDR_W'(irqLevel) << 1);
  end
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          SUB_W      = 6,
  parameter int          TRAP_LEVEL = 4,
  parameter int          PARTY_A    = 10,
  parameter int          PARTY_B    = 11,
  parameter logic [15:0] VEC_BASE   = 16'h0040,
  parameter logic [15:0] SUB_BASE_A = 16'h0100,
  parameter logic [15:0] SUB_BASE_B = 16'h0180
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] hwReq,
  input  logic                  trapReq,
  input  logic [SUB_W-1:0]      subCodeA,
  input  logic [SUB_W-1:0]      subCodeB,
  input  logic                  cmdValid,
  input  logic [2:0]            cmdOp,
  input  logic [NUM_LEVELS-1:0] cmdMask,
  input  logic                  intAck,
  output logic                  irqValid,
  output logic [LVL_W-1:0]      irqLevel,
  output logic [ADDR_W-1:0]     vecPairAddr,
  output logic [NUM_LEVELS-1:0] reqState,
  output logic [NUM_LEVELS-1:0] enState,
  output logic [NUM_LEVELS-1:0] actState
);
  picStrobe_t strobe;
  lvlVec_t    reqQ;
  lvlVec_t    enQ;
  lvlVec_t    actQ;

  pic_ctrl #(.TRAP_LEVEL(TRAP_LEVEL)) u_ctrl (
    .reqQ(reqQ), .enQ(enQ), .actQ(actQ), .hwReq(hwReq), .trapReq(trapReq),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdMask(cmdMask), .intAck(intAck),
    .irqValid(irqValid), .irqLevel(irqLevel), .strobe(strobe)
  );

  pic_dpath #(
    .ADDR_W(ADDR_W), .SUB_W(SUB_W), .PARTY_A(PARTY_A), .PARTY_B(PARTY_B),
    .VEC_BASE(VEC_BASE), .SUB_BASE_A(SUB_BASE_A), .SUB_BASE_B(SUB_BASE_B)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqLevel(irqLevel),
    .subCodeA(subCodeA), .subCodeB(subCodeB),
    .reqQ(reqQ), .enQ(enQ), .actQ(actQ), .vecPairAddr(vecPairAddr)
  );

  assign reqState = reqQ;
  assign enState  = enQ;
  assign actState = actQ;
endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import pic_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          TRAP_LEVEL = 4,
  parameter int          PARTY_A    = 10,
  parameter int          PARTY_B    = 11,
  parameter logic [15:0] VEC_BASE   = 16'h0040
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_LEVELS-1:0] hwReq,
  input logic                  trapReq,
  input logic                  cmdValid,
  input logic [2:0]            cmdOp,
  input logic                  intAck,
  input logic                  irqValid,
  input logic [LVL_W-1:0]      irqLevel,
  input logic [ADDR_W-1:0]     vecPairAddr,
  input logic [NUM_LEVELS-1:0] reqState,
  input logic [NUM_LEVELS-1:0] enState,
  input logic [NUM_LEVELS-1:0] actState
);
  logic [NUM_LEVELS-1:0] upToLvl;
  always_comb
    for (int i = 0; i < NUM_LEVELS; i++) upToLvl[i] = (i <= int'(irqLevel));

  assert_hw_sets_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|hwReq) |=> ((reqState & $past(hwReq)) == $past(hwReq)));

  assert_trap_sets_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> reqState[TRAP_LEVEL]);

  assert_offer_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (reqState[irqLevel] && enState[irqLevel]));

  assert_offer_unblocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ((actState & upToLvl) == '0));

  assert_ack_marks_active_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && intAck && !cmdValid) |=> actState[$past(irqLevel)]);

  assert_return_drops_one_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd6 && !(irqValid && intAck) && (|actState))
    |=> ($countones(actState) == $past($countones(actState)) - 1));

  assert_plain_vector_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && irqLevel != LVL_W'(PARTY_A) && irqLevel != LVL_W'(PARTY_B))
    |-> (vecPairAddr == ADDR_W'(VEC_BASE) + (ADDR_W'(irqLevel) << 1)));

  assert_idle_ack_no_effect_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!irqValid && !cmdValid && hwReq == '0 && !trapReq)
    |=> ($stable(reqState) && $stable(enState) && $stable(actState)));
endmodule

bind pic_top pic_checker #(
  .ADDR_W(ADDR_W), .TRAP_LEVEL(TRAP_LEVEL), .PARTY_A(PARTY_A),
  .PARTY_B(PARTY_B), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .hwReq(hwReq), .trapReq(trapReq),
  .cmdValid(cmdValid), .cmdOp(cmdOp), .intAck(intAck), .irqValid(irqValid),
  .irqLevel(irqLevel), .vecPairAddr(vecPairAddr), .reqState(reqState),
  .enState(enState), .actState(actState)
);

// File: tb/sim_pic_top.sv
`timescale 1ns/1ps
module sim_pic_top;
  localparam int N    = 16;
  localparam int TRAP = 4;
  localparam int PA   = 10;
  localparam int PB   = 11;
  localparam logic [15:0] VB  = 16'h0040;
  localparam logic [15:0] SBA = 16'h0100;
  localparam logic [15:0] SBB = 16'h0180;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] hwReq = '0;
  logic trapReq = 1'b0;
  logic [5:0] subCodeA = '0;
  logic [5:0] subCodeB = '0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd7;
  logic [N-1:0] cmdMask = '0;
  logic intAck = 1'b0;
  logic irqValid;
  logic [3:0] irqLevel;
  logic [15:0] vecPairAddr;
  logic [N-1:0] reqState, enState, actState;

  int checks = 0;
  int fails = 0;
  logic finished = 1'b0;
  logic [N-1:0] mReq = '0, mEn = '0, mAct = '0;

  always #10 clk = ~clk;  // 50 MHz

  pic_top u0 (
    .clk(clk), .rstN(rstN), .hwReq(hwReq), .trapReq(trapReq),
    .subCodeA(subCodeA), .subCodeB(subCodeB), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdMask(cmdMask), .intAck(intAck), .irqValid(irqValid),
    .irqLevel(irqLevel), .vecPairAddr(vecPairAddr), .reqState(reqState),
    .enState(enState), .actState(actState)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] arbitrate(logic [N-1:0] r, logic [N-1:0] e, logic [N-1:0] a);
    for (int i = 0; i < N; i++) begin
      if (a[i]) return 5'd0;
      if (r[i] && e[i]) return {1'b1, 4'(i)};
    end
    return 5'd0;
  endfunction

  function automatic logic [15:0] expVec(int lvl, logic [5:0] sa, logic [5:0] sb);
    if (lvl == PA) return SBA + 16'(sa) * 16'd2;
    if (lvl == PB) return SBB + 16'(sb) * 16'd2;
    return VB + 16'(lvl) * 16'd2;
  endfunction

  // one clock: inputs already driven after a falling edge
  task automatic cycle(string tag);
    logic [4:0] arb;
    logic [N-1:0] nReq, nEn, nAct, lowAct;
    #1;
    arb = arbitrate(mReq, mEn, mAct);
    chk(tag, "irqValid", 32'(irqValid), 32'(arb[4]));
    if (arb[4]) begin
      chk(tag, "irqLevel", 32'(irqLevel), 32'(arb[3:0]));
      chk(tag, "vecPairAddr", 32'(vecPairAddr),
          32'(expVec(int'(arb[3:0]), subCodeA, subCodeB)));
    end
    nReq = mReq; nEn = mEn; nAct = mAct;
    if (arb[4] && intAck) begin
      nReq[arb[3:0]] = 1'b0;
      nAct[arb[3:0]] = 1'b1;
    end
    lowAct = mAct & (~mAct + 1'b1);
    if (cmdValid) begin
      case (cmdOp)
        3'd0: nReq = nReq | cmdMask;
        3'd1: nReq = nReq & ~cmdMask;
        3'd2: nEn  = nEn | cmdMask;
        3'd3: nEn  = nEn & ~cmdMask;
        3'd4: nAct = nAct | cmdMask;
        3'd5: nAct = nAct & ~cmdMask;
        3'd6: nAct = nAct & ~lowAct;
        default: ;
      endcase
    end
    nReq = nReq | hwReq;
    if (trapReq) nReq[TRAP] = 1'b1;
    @(posedge clk);
    #1;
    mReq = nReq; mEn = nEn; mAct = nAct;
    chk(tag, "reqState", 32'(reqState), 32'(mReq));
    chk(tag, "enState", 32'(enState), 32'(mEn));
    chk(tag, "actState", 32'(actState), 32'(mAct));
    @(negedge clk);
  endtask

  task automatic idle();
    hwReq = '0; trapReq = 1'b0; cmdValid = 1'b0; cmdOp = 3'd7;
    cmdMask = '0; intAck = 1'b0;
  endtask

  task automatic cmd(logic [2:0] op, logic [N-1:0] m, string tag);
    idle(); cmdValid = 1'b1; cmdOp = op; cmdMask = m;
    cycle(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk("R1", "irqValid in reset", 32'(irqValid), 32'd0);
    chk("R1", "reqState in reset", 32'(reqState), 32'd0);
    chk("R1", "enState in reset", 32'(enState), 32'd0);
    chk("R1", "actState in reset", 32'(actState), 32'd0);
    rstN = 1'b1;
    idle();
    cycle("R1");

    // R9: pending on a disabled level gives no offer
    cmd(3'd0, 16'h0080, "R9");
    idle(); cycle("R9");
    // R10: acknowledge while nothing offered
    idle(); intAck = 1'b1; cycle("R10");
    // enable level 7 -> offer, vector 0x4E (R7)
    cmd(3'd2, 16'h0080, "R9");
    idle(); cycle("R7");
    chk("R7", "vector of level 7", 32'(vecPairAddr), 32'h004E);
    // R5: acknowledge level 7
    idle(); intAck = 1'b1; cycle("R5");
    // R4: enable all; level 9 blocked by active 7, level 3 offered
    cmd(3'd2, 16'hFFFF, "R3");
    idle(); hwReq = 16'h0200; cycle("R4");
    chk("R4", "level 9 blocked", 32'(irqValid), 32'd0);
    idle(); hwReq = 16'h0008; cycle("R2");
    idle(); intAck = 1'b1; cycle("R5");
    // R6: return retires level 3 only; then level 7 leaves too
    cmd(3'd6, 16'h0000, "R6");
    chk("R6", "active after return", 32'(actState), 32'h0080);
    cmd(3'd6, 16'hFFFF, "R6");
    // R2: trap and hardware set beats same-cycle clear
    idle(); trapReq = 1'b1; cycle("R2");
    idle(); cmdValid = 1'b1; cmdOp = 3'd1; cmdMask = 16'hFFFF; hwReq = 16'h0001;
    cycle("R2");
    chk("R2", "hw set over clear", 32'(reqState), 32'h0001);
    // R8: shared lines with extreme codes
    cmd(3'd1, 16'hFFFF, "R3");
    cmd(3'd0, 16'h0400, "R8");
    idle(); subCodeA = 6'd63; cycle("R8");
    chk("R8", "shared line A code 63", 32'(vecPairAddr), 32'h017E);
    cmd(3'd1, 16'hFFFF, "R3");
    cmd(3'd0, 16'h0800, "R8");
    idle(); subCodeB = 6'd0; cycle("R8");
    chk("R8", "shared line B code 0", 32'(vecPairAddr), 32'h0180);
    // R3: command code 7 does nothing, active set/clear by mask
    cmd(3'd7, 16'hFFFF, "R3");
    cmd(3'd4, 16'h8001, "R3");
    cmd(3'd5, 16'h0001, "R3");
    cmd(3'd1, 16'hFFFF, "R3");
    cmd(3'd5, 16'hFFFF, "R3");

    // random phase
    for (int k = 0; k < 4000; k++) begin
      idle();
      if (($urandom % 10) < 3) begin
        cmdValid = 1'b1;
        cmdOp = 3'($urandom % 8);
        cmdMask = N'($urandom & $urandom);
      end
      if (($urandom % 6) == 0) hwReq[$urandom % N] = 1'b1;
      trapReq = (($urandom % 20) == 0);
      intAck = $urandom % 2 == 1;
      subCodeA = 6'($urandom);
      subCodeB = 6'($urandom);
      cycle("R3");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule